// File: doc/BRIEF.md
# Integer Tile Multiply-Accumulate Unit

This block updates a 4x4 tile of 32-bit accumulators with the signed dot products of two operand tiles. Each operand tile is four rows of 128 bits. The opcode decides how a row is split: into sixteen signed bytes, eight signed halfwords or four signed words. The same row bits can therefore feed dot products of three different lengths into the same 32-bit output element. A fourth opcode clears the destination tile.

The caller presents the opcode, the two source tiles and the current accumulator tile as flat vectors, together with a valid strobe. A transfer takes place on a clock edge where both valid and ready are high. The updated tile appears two edges later. It stays on the output until the next result replaces it. The register file that holds the tiles sits outside this block.

Top module: `imma_tile_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `res_valid` is 0, `op_ready` is 1 and `res_tile` is all zero.
- R2: Opcode 0 (clear) produces a result tile in which every element is zero, whatever the accumulator and source tiles hold.
- R3: Opcode 1 (byte) splits each row into 16 signed 8-bit lanes. Lane k is bits 8k+7..8k of the row. Each output element adds the sum of the 16 lane products.
- R4: Opcode 2 (halfword) splits each row into 8 signed 16-bit lanes. Lane k is bits 16k+15..16k. Each output element adds the sum of the 8 lane products.
- R5: Opcode 3 (word) splits each row into 4 signed 32-bit lanes. Lane k is bits 32k+31..32k. Each output element adds the sum of the 4 lane products.
- R6: Row i of a source tile is bits 128i+127..128i. Element (i,j) of the accumulator and result tiles is bits 32(4i+j)+31..32(4i+j). Result (i,j) equals accumulator (i,j) plus the dot product of row i of `src_a` and row j of `src_b`.
- R7: All products and sums wrap modulo 2^32 without saturation. For example, 0x7FFFFFFF plus a byte dot product of 16 gives 0x8000000F.
- R8: `res_valid` is a one-cycle pulse two clock edges after the accepting edge. `res_tile` changes only when `res_valid` is high, and it keeps its value until the next result.
- R9: `op_ready` is 0 in the cycle that follows an accepting edge. Operations offered while `op_ready` is 0 are not accepted and produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | The block can accept an operation this cycle |
| op_code | input | 2 | 0 clear, 1 byte, 2 halfword, 3 word |
| acc_tile | input | 512 | Current accumulator tile, 16 elements of 32 bits |
| src_a | input | 512 | Left operand tile, 4 rows of 128 bits |
| src_b | input | 512 | Right operand tile, 4 rows of 128 bits |
| res_valid | output | 1 | The result tile is new this cycle |
| res_tile | output | 512 | Updated accumulator tile |

## Verification
The assertions assume that operands are sampled only on an accepting edge and that the caller keeps no second operation in flight. Beyond the handshake they assume nothing about `op_valid`. The stimulus still offers a different operation while `op_ready` is low, and then checks that no result follows. The zero-row property in the dot-product unit assumes a clean two-state row. The bench therefore always drives every operand bit. It uses sign-heavy patterns (all-ones lanes, extreme positive words) to reach wraparound without leaving the specified encodings.

// File: rtl/imma_pkg.sv
package imma_pkg;
  localparam int TILE_DIM = 4;
  localparam int ROW_W    = 128;
  localparam int ACC_W    = 32;
  localparam int N_ELEM   = TILE_DIM * TILE_DIM;
  localparam int TILE_W   = TILE_DIM * ROW_W;
  localparam int RES_W    = N_ELEM * ACC_W;

  typedef enum logic [1:0] {
    IMMA_CLEAR = 2'd0,
    IMMA_BYTE  = 2'd1,
    IMMA_HALF  = 2'd2,
    IMMA_WORD  = 2'd3
  } imma_op_e;
endpackage

// File: rtl/imma_lane_dot.sv
// Fixed-width signed dot product of one row pair, truncated to ACC_W bits.
module imma_lane_dot #(
  parameter int ROW_W  = 128,
  parameter int LANE_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic [ROW_W-1:0] a_row,
  input  logic [ROW_W-1:0] b_row,
  output logic [ACC_W-1:0] dot
);
  localparam int LANES = ROW_W / LANE_W;

  logic [ACC_W-1:0] prod [LANES];

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      logic signed [LANE_W-1:0] ea, eb;
      logic signed [ACC_W-1:0]  xa, xb;
      assign ea = a_row[k*LANE_W +: LANE_W];
      assign eb = b_row[k*LANE_W +: LANE_W];
      assign xa = ACC_W'(ea);
      assign xb = ACC_W'(eb);
      assign prod[k] = xa * xb;
    end
  endgenerate

  always_comb begin
    dot = '0;
    for (int i = 0; i < LANES; i++) dot = dot + prod[i];
  end
endmodule

// File: rtl/imma_row_dot.sv
// Selects among byte, halfword and word dot products of one row pair.
module imma_row_dot
  import imma_pkg::*;
#(
  parameter int ROW_W = 128,
  parameter int ACC_W = 32
) (
  input  imma_op_e         op,
  input  logic [ROW_W-1:0] a_row,
  input  logic [ROW_W-1:0] b_row,
  output logic [ACC_W-1:0] dot
);
  localparam int N_WIDTHS = 3;
  logic [ACC_W-1:0] dot_w [N_WIDTHS];

  genvar w;
  generate
    for (w = 0; w < N_WIDTHS; w++) begin : g_width
      imma_lane_dot #(.ROW_W(ROW_W), .LANE_W(8 << w), .ACC_W(ACC_W)) u_lane (
        .a_row(a_row),
        .b_row(b_row),
        .dot  (dot_w[w])
      );
    end
  endgenerate

  always_comb begin
    unique case (op)
      IMMA_BYTE: dot = dot_w[0];
      IMMA_HALF: dot = dot_w[1];
      IMMA_WORD: dot = dot_w[2];
      default:   dot = '0;
    endcase
  end

  // R3 R4 R5: a zero left row contributes nothing in any width
  always_comb begin
    if (a_row == '0)
      a_r3_zero_row: assert (dot == '0);
  end
endmodule

// File: rtl/imma_ctrl.sv
// Handshake and two-stage valid pipeline.
module imma_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic op_valid,
  output logic op_ready,
  output logic fire,
  output logic s1_v,
  output logic res_valid
);
  assign op_ready = ~s1_v;
  assign fire     = op_valid & op_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v      <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      s1_v      <= fire;
      res_valid <= s1_v;
    end
  end

  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready) |-> ##2 res_valid);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready) |=> !op_ready);
endmodule

// File: rtl/imma_tile_unit.sv
module imma_tile_unit
  import imma_pkg::*;
#(
  parameter int DIM   = TILE_DIM,
  parameter int RW    = ROW_W,
  parameter int AW    = ACC_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  op_valid,
  output logic                  op_ready,
  input  logic [1:0]            op_code,
  input  logic [DIM*DIM*AW-1:0] acc_tile,
  input  logic [DIM*RW-1:0]     src_a,
  input  logic [DIM*RW-1:0]     src_b,
  output logic                  res_valid,
  output logic [DIM*DIM*AW-1:0] res_tile
);
  localparam int NE = DIM * DIM;

  logic     fire, s1_v;
  imma_op_e op;
  logic     clr_q;

  assign op = imma_op_e'(op_code);

  imma_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_ready (op_ready),
    .fire     (fire),
    .s1_v     (s1_v),
    .res_valid(res_valid)
  );

  always_ff @(posedge clk) begin
    if (rst)       clr_q <= 1'b0;
    else if (fire) clr_q <= (op == IMMA_CLEAR);
  end

  genvar i, j;
  generate
    for (i = 0; i < DIM; i++) begin : g_row
      for (j = 0; j < DIM; j++) begin : g_col
        localparam int E = i * DIM + j;
        logic [AW-1:0] dot_c, dot_q, acc_q, res_q;

        imma_row_dot #(.ROW_W(RW), .ACC_W(AW)) u_dot (
          .op   (op),
          .a_row(src_a[i*RW +: RW]),
          .b_row(src_b[j*RW +: RW]),
          .dot  (dot_c)
        );

        // stage 1: capture dot product and accumulator
        always_ff @(posedge clk) begin
          if (fire) begin
            dot_q <= dot_c;
            acc_q <= acc_tile[E*AW +: AW];
          end
        end

        // stage 2: accumulate with modular wrap, or clear
        always_ff @(posedge clk) begin
          if (rst)       res_q <= '0;
          else if (s1_v) res_q <= clr_q ? '0 : acc_q + dot_q;
        end

        assign res_tile[E*AW +: AW] = res_q;
      end
    end
  endgenerate

  a_r2_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (s1_v && clr_q) |=> (res_tile == '0));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_tile) |-> res_valid);
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> op_ready);
endmodule

// File: tb/sim_imma_tile_unit.sv
module sim_imma_tile_unit;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 512;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic          op_ready;
  logic [1:0]    op_code = 2'd0;
  logic [TW-1:0] acc_tile = '0, src_a = '0, src_b = '0;
  logic          res_valid;
  logic [TW-1:0] res_tile;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imma_tile_unit u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .acc_tile(acc_tile), .src_a(src_a), .src_b(src_b),
    .res_valid(res_valid), .res_tile(res_tile)
  );

  // op[97:96], seed A, seed B, seed C
  localparam logic [97:0] VECS [0:7] = '{
    {2'd1, 32'h0000_0001, 32'h0000_0002, 32'h0000_0000},
    {2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678},
    {2'd2, 32'h8001_7FFF, 32'h7FFF_8001, 32'h0000_0010},
    {2'd2, 32'hDEAD_BEEF, 32'hCAFE_F00D, 32'hFFFF_FFF0},
    {2'd3, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0000_0000},
    {2'd3, 32'h8000_0000, 32'h1357_9BDF, 32'h0BAD_F00D},
    {2'd0, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h7777_7777},
    {2'd1, 32'h0F1E_2D3C, 32'hF0E1_D2C3, 32'h8000_0000}
  };

  function automatic logic [TW-1:0] fill(input logic [31:0] seed);
    logic [TW-1:0] t = '0;
    for (int w = 0; w < 16; w++)
      t[w*32 +: 32] = (w[0] ? seed : ~seed) ^ (32'(w) * 32'h0101_0101);
    return t;
  endfunction

  function automatic longint lane(input logic [TW-1:0] t, input int pos, input int w);
    logic [TW-1:0] s = t >> pos;
    longint mask = (longint'(1) << w) - 1;
    longint v = longint'(s[63:0]) & mask;
    if (((v >> (w - 1)) & 1) == 1) v = v - (longint'(1) << w);
    return v;
  endfunction

  function automatic logic [TW-1:0] model(input logic [1:0] op,
      input logic [TW-1:0] a, input logic [TW-1:0] b, input logic [TW-1:0] c);
    logic [TW-1:0] r = '0;
    int w = (op == 2'd1) ? 8 : (op == 2'd2) ? 16 : 32;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        longint s = longint'(c[(i*4+j)*32 +: 32]);
        for (int k = 0; k < 128 / w; k++)
          s = s + lane(a, i*128 + k*w, w) * lane(b, j*128 + k*w, w);
        r[(i*4+j)*32 +: 32] = (op == 2'd0) ? 32'd0 : s[31:0];
      end
    return r;
  endfunction

  task automatic check(input bit ok, input string req,
      input logic [TW-1:0] act, input logic [TW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [TW-1:0] a,
      input logic [TW-1:0] b, input logic [TW-1:0] c, input string req);
    logic [TW-1:0] exp = model(op, a, b, c);
    op_code = op; src_a = a; src_b = b; acc_tile = c; op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    check(!op_ready && !res_valid, "R9 busy after accept",
          TW'({op_ready, res_valid}), '0);
    @(posedge clk);
    @(negedge clk);
    check(res_valid, "R8 valid after two edges", TW'(res_valid), TW'(1));
    check(res_tile == exp, req, res_tile, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!res_valid && op_ready && res_tile == '0, "R1 in reset",
          res_tile, '0);
    rst = 1'b0;
    @(negedge clk);
    check(!res_valid && op_ready && res_tile == '0, "R1 after reset",
          res_tile, '0);

    // table walk: R3 R4 R5 R6 R2
    for (int v = 0; v < 8; v++) begin
      logic [97:0] e = VECS[v];
      run_op(e[97:96], fill(e[95:64]), fill(e[63:32]), fill(e[31:0]),
             (e[97:96] == 2'd0) ? "R2 clear" :
             (e[97:96] == 2'd1) ? "R3 byte R6" :
             (e[97:96] == 2'd2) ? "R4 half R6" : "R5 word R6");
    end

    // R6: single nonzero lanes locate rows and elements
    begin
      logic [TW-1:0] a = '0, b = '0, c = '0, exp = '0;
      a[2*128 +: 8] = 8'd3;
      b[1*128 +: 8] = 8'd5;
      exp[(2*4+1)*32 +: 32] = 32'd15;
      run_op(2'd1, a, b, c, "R6 element placement");
      check(res_tile[(2*4+1)*32 +: 32] == 32'd15, "R6 element (2,1)",
            TW'(res_tile[(2*4+1)*32 +: 32]), TW'(15));
    end

    // R7: wrap without saturation
    begin
      logic [TW-1:0] a = {64{8'h01}}, c = {16{32'h7FFF_FFFF}};
      run_op(2'd1, a, a, c, "R7 byte wrap");
      check(res_tile[31:0] == 32'h8000_000F, "R7 wrap value",
            TW'(res_tile[31:0]), TW'(32'h8000_000F));
    end

    // R3: all-ones bytes are -1, product +1 each
    begin
      logic [TW-1:0] a = {TW{1'b1}}, c = '0;
      run_op(2'd1, a, a, c, "R3 signed bytes");
      check(res_tile[31:0] == 32'd16, "R3 minus one lanes",
            TW'(res_tile[31:0]), TW'(16));
    end

    // R8 hold and R9 ignored offer while busy
    begin
      logic [TW-1:0] kept;
      logic [TW-1:0] a = fill(32'h0246_8ACE);
      logic [TW-1:0] exp = model(2'd2, a, a, '0);
      op_code = 2'd2; src_a = a; src_b = a; acc_tile = '0; op_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      op_code = 2'd0; acc_tile = {TW{1'b1}};
      check(!op_ready, "R9 ready low", TW'(op_ready), '0);
      @(posedge clk);
      @(negedge clk);
      op_valid = 1'b0;
      check(res_valid && res_tile == exp, "R9 first op result", res_tile, exp);
      kept = res_tile;
      for (int t = 0; t < 4; t++) begin
        @(negedge clk);
        check(!res_valid && res_tile == kept, "R9 ignored offer / R8 hold",
              res_tile, kept);
      end
    end

    // R8 back-to-back: accept on the result cycle
    begin
      logic [TW-1:0] a = fill(32'h1111_2222);
      logic [TW-1:0] e1 = model(2'd3, a, a, '0);
      logic [TW-1:0] e2 = model(2'd1, a, a, e1);
      op_code = 2'd3; src_a = a; src_b = a; acc_tile = '0; op_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      op_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      check(res_valid && op_ready && res_tile == e1, "R8 first of pair",
            res_tile, e1);
      op_code = 2'd1; acc_tile = res_tile; op_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      op_valid = 1'b0;
      check(!res_valid, "R8 pulse one cycle", TW'(res_valid), '0);
      @(posedge clk); @(negedge clk);
      check(res_valid && res_tile == e2, "R8 second of pair", res_tile, e2);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule